// File: doc/BRIEF.md
# Multidrop Serial Receiver with Sleep Mode

This block receives asynchronous serial characters on one line and places each one in a receive data register with status flags. The line is oversampled by a tick input at sixteen ticks per bit time. Each character is a low start bit, eight data bits sent least significant bit first, an optional parity bit and a high stop bit. The block reports noise, framing and parity errors, overrun and an idle line.

On a multidrop line a node often has to skip characters that are meant for other nodes. Software pulses `wake_req` to put the receiver to sleep. While it sleeps, characters on the line are dropped, no status flag is raised and the interrupt request stays low. The receiver wakes by itself on one of two conditions, chosen by `wake_on_mark`. The first is an idle line. The second is a character whose top data bit, the address mark, is set. Software clears the flags by pulsing `rd_ack` after it reads them.

Top module: `uart_wake_rx`

## Requirements
- R1: A frame starts with a low start bit, followed by 8 data bits least significant bit first, then a parity bit when `par_en` is 1, then a stop bit. When the stop bit has been sampled and the receiver is awake, `rx_data` takes the 8 data bits and `rx_full` goes to 1.
- R2: A pulse on `wake_req` sets `asleep` to 1. While `asleep` is 1, a character that does not wake the receiver leaves `rx_data` and `rx_full` unchanged.
- R3: While `asleep` is 1, none of `rx_full`, `err_noise`, `err_frame`, `err_parity`, `overrun` or `line_idle` becomes set, and `rx_irq` is 0.
- R4: When `wake_on_mark` is 0, an idle line detected during sleep clears `asleep` in the same cycle. That idle event does not set `line_idle`, and the next character is received normally.
- R5: With `par_en` at 1, `err_parity` is set when the number of ones in the data bits plus the parity bit is odd while `par_odd` is 0, or even while `par_odd` is 1. With `par_en` at 0, `err_parity` is never set.
- R6: `err_frame` is set when the stop-bit value is 0. `err_noise`, `err_frame` and `err_parity` are loaded in the same clock edge that sets `rx_full`.
- R7: Each bit value is the majority of the line samples taken at ticks 7, 8 and 9 of its bit time, counting from 0. `err_noise` is set when those three samples disagree for any bit of the frame.
- R8: `line_idle` is set after one full character time of ticks sampling 1 (16 x 10 ticks, or 16 x 11 ticks with parity). The count starts only after at least one 0 has been sampled since the last idle event, so a line that stays high raises it only once.
- R9: When a character completes while `rx_full` is still 1, `overrun` is set, and `rx_data` and the error flags keep their old values.
- R10: When `wake_on_mark` is 1, idle lines do not wake the receiver. A character with data bit 7 set clears `asleep` and is itself received normally.
- R11: A pulse on `rd_ack` clears `rx_full`, `overrun`, `err_noise`, `err_frame`, `err_parity` and `line_idle`. `rx_irq` is 1 when `asleep` is 0 and either `rx_full` or `line_idle` is 1.
- R12: A low pulse whose start-bit samples give a majority of 1 is treated as a false start. No character is produced from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling strobe, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | Parity bit present in frame |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| wake_on_mark | input | 1 | Wake condition: 0 selects idle line, 1 selects address mark |
| wake_req | input | 1 | Pulse to enter sleep |
| rd_ack | input | 1 | Pulse to clear all status flags |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | New data present |
| overrun | output | 1 | Character lost because `rx_full` was still set |
| err_noise | output | 1 | Sample disagreement in the last received frame |
| err_frame | output | 1 | Stop bit read as 0 |
| err_parity | output | 1 | Parity mismatch |
| line_idle | output | 1 | Idle line detected |
| asleep | output | 1 | Sleep mode active |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench targets four cases. The first is a glitch on the middle sample of one data bit: a receiver that uses that sample alone stores a flipped bit, and one that ignores disagreement misses `err_noise`. The second is a character that arrives before `rx_full` is cleared: a receiver that gets this wrong overwrites the held data or misses `overrun`. The third is the sleep sequence in both wake modes: a faulty receiver lets ignored characters through, raises flags while asleep, wakes on the wrong condition, or drops the address-mark character that woke it. The last case is a line held high for a long time: a detector that is not re-armed by a 0 raises idle over and over, which the bench catches by clearing the flag and waiting.

// File: rtl/uart_wake_rx_pkg.sv
package uart_wake_rx_pkg;

    typedef enum logic [0:0] {
        ST_HUNT,
        ST_FRAME
    } rx_state_e;

    typedef struct packed {
        logic noise;
        logic frame;
        logic parity;
    } rx_err_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic split3(input logic a, input logic b, input logic c);
        return (a != b) || (b != c);
    endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
    import uart_wake_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 rxd,
    input  logic                 par_en,
    input  logic                 par_odd,
    output logic                 done_o,
    output logic [DATA_BITS-1:0] data_o,
    output rx_err_t              err_o
);
    localparam int CW    = $clog2(OVS);
    localparam int BW    = $clog2(DATA_BITS + 3);
    localparam int S_LO  = OVS / 2 - 1;
    localparam int S_MID = OVS / 2;
    localparam int S_HI  = OVS / 2 + 1;

    rx_state_e            state;
    logic [CW-1:0]        cnt;
    logic [BW-1:0]        bidx;
    logic [1:0]           smp;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_acc;
    logic                 noise_acc;
    logic                 bit_v;
    logic                 nz;
    logic [BW-1:0]        last_idx;

    assign bit_v    = vote3(smp[0], smp[1], rxd);
    assign nz       = split3(smp[0], smp[1], rxd);
    assign last_idx = par_en ? BW'(DATA_BITS + 2) : BW'(DATA_BITS + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT;
            cnt       <= '0;
            bidx      <= '0;
            smp       <= '0;
            shreg     <= '0;
            par_acc   <= 1'b0;
            noise_acc <= 1'b0;
            done_o    <= 1'b0;
            data_o    <= '0;
            err_o     <= '0;
        end else begin
            done_o <= 1'b0;
            if (tick) begin
                case (state)
                    ST_HUNT: begin
                        if (!rxd) begin
                            state     <= ST_FRAME;
                            cnt       <= CW'(1);
                            bidx      <= '0;
                            noise_acc <= 1'b0;
                            par_acc   <= 1'b0;
                        end
                    end
                    ST_FRAME: begin
                        cnt <= (cnt == CW'(OVS - 1)) ? '0 : cnt + 1'b1;
                        if (cnt == CW'(OVS - 1)) begin
                            bidx <= bidx + 1'b1;
                        end
                        if (cnt == CW'(S_LO)) begin
                            smp[0] <= rxd;
                        end
                        if (cnt == CW'(S_MID)) begin
                            smp[1] <= rxd;
                        end
                        if (cnt == CW'(S_HI)) begin
                            if (bidx == '0) begin
                                if (bit_v) begin
                                    state <= ST_HUNT;
                                end
                                noise_acc <= nz;
                            end else if (bidx <= BW'(DATA_BITS)) begin
                                shreg     <= {bit_v, shreg[DATA_BITS-1:1]};
                                par_acc   <= par_acc ^ bit_v;
                                noise_acc <= noise_acc | nz;
                            end else if (bidx == last_idx) begin
                                done_o       <= 1'b1;
                                data_o       <= shreg;
                                err_o.noise  <= noise_acc | nz;
                                err_o.frame  <= ~bit_v;
                                err_o.parity <= par_en & (par_acc ^ par_odd);
                                state        <= ST_HUNT;
                            end else begin
                                par_acc   <= par_acc ^ bit_v;
                                noise_acc <= noise_acc | nz;
                            end
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end

    // R1: a completed frame is a single-cycle event
    a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R1: the bit index never runs past the stop bit of the longest frame
    a_r1_index_bound: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FRAME) |-> (bidx <= BW'(DATA_BITS + 2)));

    // R12: a frame only completes out of the frame state
    a_r12_done_from_frame: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(state) == ST_FRAME));

endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rxd,
    input  logic par_en,
    output logic idle_o
);
    localparam int MAX_TICKS = OVS * (DATA_BITS + 3);
    localparam int LW        = $clog2(MAX_TICKS + 1);

    logic [LW-1:0] run;
    logic [LW-1:0] lim;
    logic          armed;

    assign lim = par_en ? LW'(OVS * (DATA_BITS + 3)) : LW'(OVS * (DATA_BITS + 2));

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= '0;
            armed  <= 1'b0;
            idle_o <= 1'b0;
        end else begin
            idle_o <= 1'b0;
            if (tick) begin
                if (!rxd) begin
                    run   <= '0;
                    armed <= 1'b1;
                end else if (armed) begin
                    if (run == lim - 1'b1) begin
                        idle_o <= 1'b1;
                        armed  <= 1'b0;
                        run    <= '0;
                    end else begin
                        run <= run + 1'b1;
                    end
                end
            end
        end
    end

    // R8: the idle event fires once and then needs re-arming
    a_r8_one_shot: assert property (@(posedge clk) disable iff (rst)
        idle_o |=> !idle_o);

    // R8: the event follows a high line sample
    a_r8_after_high: assert property (@(posedge clk) disable iff (rst)
        idle_o |-> $past(rxd));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_wake_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_done,
    input  logic [DATA_BITS-1:0] frame_data,
    input  rx_err_t              frame_err,
    input  logic                 idle_hit,
    input  logic                 wake_req,
    input  logic                 wake_on_mark,
    input  logic                 rd_ack,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_full,
    output logic                 overrun,
    output rx_err_t              err,
    output logic                 line_idle,
    output logic                 asleep
);
    logic mark;
    logic wake_hit;
    logic sleep_next;
    logic accept;
    logic idle_set;

    assign mark       = frame_data[DATA_BITS-1];
    assign wake_hit   = asleep & (wake_on_mark ? (frame_done & mark) : idle_hit);
    assign sleep_next = wake_req | (asleep & ~wake_hit);
    assign accept     = frame_done & ~sleep_next;
    assign idle_set   = idle_hit & ~asleep & ~wake_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data   <= '0;
            rx_full   <= 1'b0;
            overrun   <= 1'b0;
            err       <= '0;
            line_idle <= 1'b0;
            asleep    <= 1'b0;
        end else begin
            asleep <= sleep_next;
            if (rd_ack) begin
                rx_full   <= 1'b0;
                overrun   <= 1'b0;
                err       <= '0;
                line_idle <= 1'b0;
            end
            if (idle_set) begin
                line_idle <= 1'b1;
            end
            if (accept) begin
                if (rx_full && !rd_ack) begin
                    overrun <= 1'b1;
                end else begin
                    rx_data <= frame_data;
                    rx_full <= 1'b1;
                    err     <= frame_err;
                end
            end
        end
    end

    // R3: no new data flag while asleep
    a_r3_quiet_full: assert property (@(posedge clk) disable iff (rst)
        asleep |-> !$rose(rx_full));

    // R3: no idle flag while asleep
    a_r3_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        asleep |-> !$rose(line_idle));

    // R4: an idle line wakes the receiver in idle mode
    a_r4_idle_wake: assert property (@(posedge clk) disable iff (rst)
        (asleep && !wake_on_mark && idle_hit && !wake_req) |=> !asleep);

    // R10: a marked character wakes the receiver and is stored
    a_r10_mark_wake: assert property (@(posedge clk) disable iff (rst)
        (asleep && wake_on_mark && frame_done && frame_data[DATA_BITS-1] && !wake_req)
        |=> (!asleep && rx_full));

    // R9: held data does not change until acknowledged
    a_r9_keep_data: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !rd_ack) |=> $stable(rx_data));

    // R6: error flags rise only with a completed frame
    a_r6_same_edge: assert property (@(posedge clk) disable iff (rst)
        ((err.noise && !$past(err.noise)) || (err.frame && !$past(err.frame)) ||
         (err.parity && !$past(err.parity))) |-> ($past(frame_done) && rx_full));

endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
    import uart_wake_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 rxd,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 wake_on_mark,
    input  logic                 wake_req,
    input  logic                 rd_ack,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_full,
    output logic                 overrun,
    output logic                 err_noise,
    output logic                 err_frame,
    output logic                 err_parity,
    output logic                 line_idle,
    output logic                 asleep,
    output logic                 rx_irq
);
    logic                 f_done;
    logic [DATA_BITS-1:0] f_data;
    rx_err_t              f_err;
    logic                 idle_hit;
    rx_err_t              err_q;

    uart_rx_sampler #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .rxd     (rxd),
        .par_en  (par_en),
        .par_odd (par_odd),
        .done_o  (f_done),
        .data_o  (f_data),
        .err_o   (f_err)
    );

    uart_rx_idle #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_idle (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .rxd    (rxd),
        .par_en (par_en),
        .idle_o (idle_hit)
    );

    uart_rx_status #(.DATA_BITS(DATA_BITS)) u_status (
        .clk          (clk),
        .rst          (rst),
        .frame_done   (f_done),
        .frame_data   (f_data),
        .frame_err    (f_err),
        .idle_hit     (idle_hit),
        .wake_req     (wake_req),
        .wake_on_mark (wake_on_mark),
        .rd_ack       (rd_ack),
        .rx_data      (rx_data),
        .rx_full      (rx_full),
        .overrun      (overrun),
        .err          (err_q),
        .line_idle    (line_idle),
        .asleep       (asleep)
    );

    assign err_noise  = err_q.noise;
    assign err_frame  = err_q.frame;
    assign err_parity = err_q.parity;
    assign rx_irq     = (rx_full | line_idle) & ~asleep;

    // R9: overrun only appears while data is held
    a_r9_overrun_held: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> rx_full);

endmodule

// File: tb/tb_uart_wake_rx.sv
`timescale 1ns/1ps
module tb_uart_wake_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       rxd = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       wake_on_mark = 1'b0;
    logic       wake_req = 1'b0;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, overrun, err_noise, err_frame, err_parity;
    logic       line_idle, asleep, rx_irq;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    uart_wake_rx dut (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .par_en(par_en),
        .par_odd(par_odd), .wake_on_mark(wake_on_mark), .wake_req(wake_req),
        .rd_ack(rd_ack), .rx_data(rx_data), .rx_full(rx_full), .overrun(overrun),
        .err_noise(err_noise), .err_frame(err_frame), .err_parity(err_parity),
        .line_idle(line_idle), .asleep(asleep), .rx_irq(rx_irq)
    );

    // {bad_stop, flip_parity, odd, parity_on, data}
    localparam logic [11:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 8'h55},
        {1'b0, 1'b0, 1'b0, 1'b1, 8'hA3},
        {1'b0, 1'b0, 1'b1, 1'b1, 8'h3C},
        {1'b0, 1'b1, 1'b0, 1'b1, 8'h81},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'h7E},
        {1'b0, 1'b1, 1'b1, 1'b1, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pen, input logic podd,
                              input logic flip, input logic bad_stop, input int glitch_bit);
        logic [10:0] bits;
        int          nb;
        bits = '0;
        bits[8:1] = d;
        if (pen) begin
            bits[9]  = (^d) ^ podd ^ flip;
            bits[10] = ~bad_stop;
            nb = 11;
        end else begin
            bits[9] = ~bad_stop;
            nb = 10;
        end
        par_en  = pen;
        par_odd = podd;
        for (int k = 0; k < nb; k++) begin
            for (int s = 0; s < 16; s++) begin
                @(negedge clk);
                rxd = (k == glitch_bit && s == 8) ? ~bits[k] : bits[k];
            end
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset full", rx_full, 0);
        check("R2 reset asleep", asleep, 0);
        check("R8 reset idle", line_idle, 0);
        check("R11 reset irq", rx_irq, 0);

        // table of frames: R1, R5, R6
        for (int i = 0; i < 6; i++) begin
            logic [11:0] v;
            v = VEC[i];
            send_frame(v[7:0], v[8], v[9], v[10], v[11], -1);
            check("R1 data", rx_data, v[7:0]);
            check("R1 full", rx_full, 1);
            check("R5 parity", err_parity, v[8] & v[10]);
            check("R6 frame", err_frame, v[11]);
            check("R7 no noise", err_noise, 0);
            check("R8 not yet idle", line_idle, 0);
            pulse_ack();
            check("R11 ack clears", rx_full, 0);
            repeat (40) @(negedge clk);
        end

        // R12 short low pulse
        @(negedge clk);
        rxd = 1'b0;
        repeat (5) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        check("R12 false start", rx_full, 0);

        // R7 glitch on middle sample of data bit 3
        send_frame(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 4);
        check("R7 vote data", rx_data, 8'h5A);
        check("R7 noise flag", err_noise, 1);
        pulse_ack();

        // R9 overrun
        send_frame(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        send_frame(8'h22, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        check("R9 overrun", overrun, 1);
        check("R9 old data kept", rx_data, 8'h11);
        check("R9 still full", rx_full, 1);
        pulse_ack();
        check("R11 overrun cleared", overrun, 0);

        // R8 idle detection and one-shot
        repeat (200) @(negedge clk);
        check("R8 idle set", line_idle, 1);
        check("R11 irq on idle", rx_irq, 1);
        pulse_ack();
        repeat (400) @(negedge clk);
        check("R8 no re-fire", line_idle, 0);

        // R4 idle-wake mode
        wake_on_mark = 1'b0;
        pulse_sleep();
        check("R2 asleep", asleep, 1);
        send_frame(8'h44, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        check("R2 ignored", rx_full, 0);
        check("R2 data unchanged", rx_data, 8'h11);
        check("R3 irq low", rx_irq, 0);
        check("R4 still asleep", asleep, 1);
        repeat (200) @(negedge clk);
        check("R4 woke on idle", asleep, 0);
        check("R4 idle not flagged", line_idle, 0);
        send_frame(8'h66, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        check("R4 receives after wake", rx_data, 8'h66);
        check("R4 full after wake", rx_full, 1);
        pulse_ack();
        repeat (200) @(negedge clk);
        check("R8 idle when awake", line_idle, 1);
        pulse_ack();

        // R10 mark-wake mode
        wake_on_mark = 1'b1;
        pulse_sleep();
        send_frame(8'h12, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        check("R10 unmarked ignored", rx_full, 0);
        send_frame(8'h20, 1'b0, 1'b0, 1'b0, 1'b1, -1);
        check("R3 no frame flag asleep", err_frame, 0);
        repeat (200) @(negedge clk);
        check("R10 idle no wake", asleep, 1);
        check("R3 no idle flag asleep", line_idle, 0);
        send_frame(8'h95, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        check("R10 woke on mark", asleep, 0);
        check("R10 mark stored", rx_data, 8'h95);
        check("R10 mark full", rx_full, 1);
        check("R11 irq awake", rx_irq, 1);
        pulse_ack();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule